// File: doc/BRIEF.md
# Sliding-Window Matrix Coefficient Encoder

This block turns one colour-transform matrix coefficient, given as a 64-bit sign-magnitude number, into the compact 16-bit word that a hardware matrix multiplier uses. In the input, bit 63 holds the sign and bits 62:0 hold an unsigned magnitude in which 1.0 is 2^32. The output word has four fields. Bit 15 carries the sign. Bits 14:12 carry a band code that tells how far the binary point has moved. Bits 11:3 carry a 9-bit mantissa, and bits 2:0 are always zero. The mantissa window slides with the magnitude, so small coefficients keep more fractional precision and large ones keep more integer range.

A limited-range option can be enabled for each coefficient. It first compresses the magnitude by 219/255, which folds the full 0..255 output swing into the 16..235 video range. The sign passes through untouched. Coefficients arrive one per clock with a valid strobe. Each encoded word appears one clock later together with its own valid flag, and the word is held until the next valid input arrives.

Top module: `coef_word_encoder`

## Requirements
- R1: Output bit 15 equals input bit 63 of the coefficient that produced the word. The sign is kept even when the magnitude is zero.
- R2: A magnitude (bits 62:0) of 4.0 (2^34) or more encodes exactly like 2^34−1. With limited range off, the result is word[14:0] = 0x6FF8.
- R3: The band is picked from the magnitude m as follows: m < 2^29 gives code 3 with f = 12; m < 2^30 gives code 2 with f = 11; m < 2^31 gives code 1 with f = 10; m < 2^32 gives code 0 with f = 9; m < 2^33 gives code 7 with f = 8; any larger m gives code 6 with f = 7. The code goes in word[14:12], so codes 4 and 5 never appear.
- R4: The mantissa is computed in three steps. Shift m right by (29 − f), then add 4, then clamp the result to 0xFFF. Bits 11:3 of the clamped value go into word[11:3]. For example, 1.0 encodes as 0x7800, and a magnitude just below a band edge saturates to a mantissa of 0xFF8.
- R5: word[2:0] is always 0.
- R6: When the limited-range enable is high, m is first clamped to 2^34−1 and shifted right by 2. It is then multiplied by 0xDBDBDBDB (floor of 219·2^32/255), and the product is shifted right by 30 before band selection. For example, +1.0 encodes as 0x0DC0.
- R7: out_valid is high exactly one clock after in_valid was high. While in_valid is low, out_word keeps its last value, whatever is on the coefficient and enable inputs.
- R8: A coefficient with only the sign bit set (negative zero) encodes as 0xB000.
- R9: While rst is high and in the cycle after it, out_valid is 0 and out_word is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Coefficient strobe |
| in_coef | input | 64 | Sign (bit 63) and 32.32 magnitude (62:0) |
| lim_en | input | 1 | Apply 219/255 limited-range compression |
| out_valid | output | 1 | Encoded word valid, one clock after in_valid |
| out_word | output | 16 | Encoded coefficient {sign, code, mantissa, 000} |

## Verification
The assertions assume that in_valid, in_coef and lim_en are known and stable at each rising edge once reset has been released. The stimulus meets this by changing every input only on the falling edge. The saturation property also assumes that lim_en is low on the same edge as the out-of-range coefficient. The bench keeps the limited-range flag as a separate, explicitly chosen input for each vector. Idle cycles drive random coefficient values and random enable levels with in_valid low, so that the hold property is exercised against changing, meaningless data.

// File: rtl/cwe_pkg.sv
package cwe_pkg;
  localparam int COEF_W    = 64;
  localparam int FRAC_W    = 32;
  localparam int MAG_W     = COEF_W - 1;
  localparam int SAT_W     = FRAC_W + 2;
  localparam int MANT_W    = 12;
  localparam int CODE_W    = 3;
  localparam int WORD_W    = 1 + CODE_W + MANT_W;
  localparam int NBANDS    = 6;
  localparam int GUARD     = 3;
  localparam int SHIFT_W   = $clog2(SAT_W) + 1;
  localparam int LIM_NUM   = 219;
  localparam int LIM_DEN   = 255;
  localparam int LIM_SHIFT = FRAC_W - 2;
  localparam logic [2*FRAC_W-1:0] LIM_K_WIDE =
    (2*FRAC_W)'((64'(LIM_NUM) << FRAC_W) / 64'(LIM_DEN));
  localparam logic [FRAC_W-1:0] LIM_K = LIM_K_WIDE[FRAC_W-1:0];

  // band 0 is the smallest magnitude band
  function automatic logic [CODE_W-1:0] band_code(input int b);
    int c;
    c = (b < 4) ? (3 - b) : (11 - b);
    return CODE_W'(c);
  endfunction

  function automatic int band_fbits(input int b);
    return MANT_W - b;
  endfunction

  function automatic int band_shift(input int b);
    return FRAC_W - GUARD - band_fbits(b);
  endfunction

  typedef struct packed {
    logic              sign;
    logic [CODE_W-1:0] code;
    logic [MANT_W-1:0] mant;
  } cw_word_t;
endpackage

// File: rtl/cwe_range_scaler.sv
module cwe_range_scaler
  import cwe_pkg::*;
#(
  parameter int IN_W  = MAG_W,
  parameter int OUT_W = SAT_W,
  parameter int FW    = FRAC_W
) (
  input  logic [IN_W-1:0]  mag_i,
  input  logic             lim_i,
  output logic [OUT_W-1:0] mag_o
);
  localparam int PROD_W = 2 * FW;

  logic [OUT_W-1:0]  sat;
  logic [FW-1:0]     quarter;
  logic [PROD_W-1:0] prod;
  logic [OUT_W-1:0]  scaled;

  // clamp strictly below 4.0
  always_comb begin
    if (|mag_i[IN_W-1:OUT_W]) sat = '1;
    else                      sat = mag_i[OUT_W-1:0];
  end

  assign quarter = sat[OUT_W-1:2];
  assign prod    = {{(PROD_W-FW){1'b0}}, quarter} * {{(PROD_W-FW){1'b0}}, LIM_K};
  assign scaled  = prod[LIM_SHIFT +: OUT_W];
  assign mag_o   = lim_i ? scaled : sat;
endmodule

// File: rtl/cwe_band_select.sv
module cwe_band_select
  import cwe_pkg::*;
#(
  parameter int MW = SAT_W,
  parameter int NB = NBANDS
) (
  input  logic [MW-1:0]      mag_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [SHIFT_W-1:0] shift_o
);
  logic [NB-2:0] below;

  genvar g;
  generate
    for (g = 0; g < NB - 1; g++) begin : g_edge
      localparam logic [MW-1:0] EDGE = MW'(1) << (FRAC_W - GUARD + g);
      assign below[g] = (mag_i < EDGE);
    end
  endgenerate

  // smallest band whose edge lies above the magnitude wins
  always_comb begin
    code_o  = band_code(NB - 1);
    shift_o = SHIFT_W'(band_shift(NB - 1));
    for (int b = NB - 2; b >= 0; b--) begin
      if (below[b]) begin
        code_o  = band_code(b);
        shift_o = SHIFT_W'(band_shift(b));
      end
    end
  end
endmodule

// File: rtl/cwe_mant_pack.sv
module cwe_mant_pack
  import cwe_pkg::*;
#(
  parameter int MW = SAT_W,
  parameter int NW = MANT_W
) (
  input  logic [MW-1:0]      mag_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [NW-1:0]      mant_o
);
  localparam logic [NW-1:0] LOW_MASK = NW'((1 << GUARD) - 1);
  localparam logic [MW:0]   ROUND    = (MW+1)'(1 << (GUARD - 1));

  logic [MW-1:0] shifted;
  logic [MW:0]   rounded;
  logic [NW-1:0] clamped;

  assign shifted = mag_i >> shift_i;
  assign rounded = {1'b0, shifted} + ROUND;

  always_comb begin
    if (|rounded[MW:NW]) clamped = '1;
    else                 clamped = rounded[NW-1:0];
  end

  assign mant_o = clamped & ~LOW_MASK;
endmodule

// File: rtl/coef_word_encoder.sv
module coef_word_encoder
  import cwe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [COEF_W-1:0] in_coef,
  input  logic              lim_en,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  logic [SAT_W-1:0]   mag;
  logic [CODE_W-1:0]  code;
  logic [SHIFT_W-1:0] shift;
  logic [MANT_W-1:0]  mant;
  cw_word_t           next_word;
  cw_word_t           word_q;
  logic               valid_q;

  cwe_range_scaler u_scale (
    .mag_i (in_coef[MAG_W-1:0]),
    .lim_i (lim_en),
    .mag_o (mag)
  );

  cwe_band_select u_band (
    .mag_i   (mag),
    .code_o  (code),
    .shift_o (shift)
  );

  cwe_mant_pack u_mant (
    .mag_i   (mag),
    .shift_i (shift),
    .mant_o  (mant)
  );

  assign next_word = '{sign: in_coef[COEF_W-1], code: code, mant: mant};

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) word_q <= next_word;
    end
  end

  assign out_valid = valid_q;
  assign out_word  = word_q;

  p_valid_lag_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_lag_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word));
  p_sign_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_word[WORD_W-1] == $past(in_coef[COEF_W-1]));
  p_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_word[GUARD-1:0] == '0);
  p_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_word[MANT_W +: CODE_W] != 3'd4 &&
                   out_word[MANT_W +: CODE_W] != 3'd5));
  p_sat_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !lim_en && |in_coef[MAG_W-1:SAT_W]) |=>
      out_word[WORD_W-2:0] == 15'h6FF8);
endmodule

// File: tb/coef_word_encoder_bench.sv
module coef_word_encoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_coef;
  logic        lim_en;
  logic        out_valid;
  logic [15:0] out_word;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [15:0] exp_word;

  always #4 clk = ~clk;

  coef_word_encoder u_coef_word_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_coef(in_coef),
    .lim_en(lim_en), .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [15:0] model(input logic [63:0] c, input bit lim);
    longint unsigned m, top, k, v;
    int codes[6] = '{3, 2, 1, 0, 7, 6};
    int f, code;
    top = 64'd1 << 34;
    m = c & ~(64'd1 << 63);
    if (m >= top) m = top - 1;
    if (lim) begin
      k = (64'd219 << 32) / 64'd255;
      m = ((m >> 2) * k) >> 30;
    end
    f = 7; code = 6;
    for (int b = 0; b < 5; b++) begin
      if (m < (64'd1 << (29 + b))) begin
        f = 12 - b; code = codes[b]; break;
      end
    end
    v = (m >> (29 - f)) + 4;
    if (v > 64'hFFF) v = 64'hFFF;
    v = v & 64'hFF8;
    return {c[63], 3'(code), 12'(v)};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [63:0] c, input bit lim, input string tag);
    in_valid = v; in_coef = c; lim_en = lim;
    if (v) exp_word = model(c, lim);
    @(negedge clk);
    check({tag, " valid"}, {15'd0, out_valid}, {15'd0, v});
    check(tag, out_word, exp_word);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      step(1'b0, {$urandom, $urandom}, 1'($urandom), "R7 hold");
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_coef = '0; lim_en = 1'b0;
    exp_word = '0;
    repeat (3) @(negedge clk);
    check("R9 reset word", out_word, 16'h0000);
    check("R9 reset valid", {15'd0, out_valid}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 after reset", {out_word[14:0], out_valid}, 16'd0);

    // directed values with known answers
    step(1'b1, 64'h0000_0001_0000_0000, 1'b0, "R4 one");
    check("R4 one literal", out_word, 16'h7800);
    step(1'b1, 64'h8000_0000_0000_0000, 1'b0, "R8 negzero");
    check("R8 literal", out_word, 16'hB000);
    step(1'b1, 64'h0000_0001_0000_0000, 1'b1, "R6 limited one");
    check("R6 literal", out_word, 16'h0DC0);
    step(1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, "R2 huge");
    check("R2 literal", out_word, 16'h6FF8);
    step(1'b1, 64'hFFFF_0000_0000_0000, 1'b1, "R2 huge limited");
    step(1'b1, 64'h0000_0004_0000_0000, 1'b0, "R2 four");
    check("R2 four literal", out_word, 16'h6FF8);
    step(1'b1, 64'h0000_0000_0000_0000, 1'b0, "R3 zero");
    check("R3 zero literal", out_word, 16'h3000);
    idle(3);

    // band edges, both signs, both modes
    for (int b = 0; b < 6; b++) begin
      for (int s = 0; s < 2; s++) begin
        for (int l = 0; l < 2; l++) begin
          longint unsigned e = 64'd1 << (29 + b);
          step(1'b1, {1'(s), 63'(e - 1)}, 1'(l), "R3 edge-1 R4");
          step(1'b1, {1'(s), 63'(e)},     1'(l), "R3 edge R1");
          step(1'b1, {1'(s), 63'(e + 1)}, 1'(l), "R3 edge+1");
          step(1'b1, {1'(s), 63'(e - (e >> 13))}, 1'(l), "R4 round-up");
          idle(1);
        end
      end
    end

    // random magnitudes spread over every band
    for (int i = 0; i < 3000; i++) begin
      int sh = $urandom_range(0, 40);
      logic [63:0] c = {$urandom, $urandom};
      c[62:0] = 63'(c[62:0] >> sh);
      step(1'b1, c, 1'($urandom), "R3 R4 R5 R6 random");
      if (out_word[2:0] != 3'b000) check("R5 low bits", out_word, {out_word[15:3], 3'b000});
      if (($urandom & 7) == 0) idle($urandom_range(1, 3));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule